// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The block controls sixteen general-purpose pins through a small byte-wide register bus. The pins are split into two banks of eight. Pin n belongs to bank n/8, and its bit within any bank-wide register is n mod 8. Each pin has two per-pin registers:

- An output-control register holds the direction, the driver type, the output value and the pull configuration. The pull and driver fields are presented unchanged as static pad-configuration outputs.
- An input-control register reads back the synchronized pad level and holds the pin's interrupt edge selection.

Pad inputs pass through a two-flop synchronizer. A selected edge on a pin latches a bit in its bank's pending register, which software clears by writing ones. A single level interrupt is the OR of all pending bits that are not masked. The mask set used depends on whether the system is active or asleep; each bank has one mask register for each state.

Writes take effect at the clock edge on which `wr_en_i` is sampled high. Reads are combinational from `addr_i`.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every output-control register reads 0x0A (push-pull input, strong pull-up enabled). Every input-control edge field is 00, both pending registers read 0x00, all four mask registers read 0xFF, and `irq_o` is 0.
- R2: The output-control register of pin n is at 0x2B + 16*(n/8) + (n mod 8), and its input-control register is 8 addresses above that. Output-control bits 5:0 read back as written, and bits 7:6 read 0. A write to one pin's register leaves every other pin's registers unchanged.
- R3: Output-control bit 5 is the direction (1 = output), bit 4 the driver (1 = open-drain) and bit 0 the value. `pad_out_o` equals bit 0. When bit 5 is 0, `pad_oe_o` is 0. When the pin is an output with push-pull, `pad_oe_o` is 1. When it is an output with open-drain, `pad_oe_o` is 1 only while bit 0 is 0.
- R4: `pull_en_o[n]` equals output-control bit 3, `pull_sel_o[2n+1:2n]` equals bits 2:1, and `open_drain_o[n]` equals bit 4. These outputs follow a write from the clock edge that stores it.
- R5: Input-control bit 0 shows the pad level delayed by two clock edges. Writes to bit 0 are ignored. Input-control bits 2:1 read back as written, and bits 7:3 read 0.
- R6: The input-control edge field, in bits 2:1, selects the interrupt edge: 00 none, 01 falling, 10 rising, 11 both. A selected edge sets pending bit n mod 8 of the register at 0x0B (bank 0) or 0x0C (bank 1). The bit can be read on the third clock edge after the pad changes, and not before.
- R7: A pin that holds a constant level never sets its pending bit, whatever its edge selection.
- R8: Writing 1 to a pending bit clears it, and bits written 0 are unchanged. When an edge is detected in the same cycle as the clear, the edge wins and the bit stays set.
- R9: Mask registers for the active state are at 0x19 (bank 0) and 0x1A (bank 1), and those for the sleep state are at 0x1B and 0x1C. A mask bit of 1 masks the pin. `irq_o` is the OR of the pending bits not masked by the active-state masks when `sleep_i` is 0, or by the sleep-state masks when `sleep_i` is 1. `irq_o` follows `sleep_i` combinationally.
- R10: A read of any address that is not mapped returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Selects the sleep-state mask set for the interrupt |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pad_in_i | input | 16 | Asynchronous pad levels |
| pad_oe_o | output | 16 | Pad output enable per pin |
| pad_out_o | output | 16 | Pad output value per pin |
| pull_en_o | output | 16 | Pull resistor enable per pin |
| pull_sel_o | output | 32 | Pull selection, two bits per pin |
| open_drain_o | output | 16 | Open-drain driver selected per pin |
| irq_o | output | 1 | Level interrupt |

## Verification
Each result is due at a different time:

- Register readback, pad enables and pad-configuration outputs are due right after the clock edge that takes the write.
- The synchronized level is due after two edges.
- A pending bit and the interrupt it raises are due after three edges.
- The interrupt also follows `sleep_i` with no clock edge in between.

The bench drives every input just after a falling edge and counts falling edges explicitly before it samples. It checks the level both one edge early and on time, and checks the pending bit after two edges and after three. A clear is placed on exactly the third rising edge after a pad change, so the collision between the clear and a new edge is tested on that cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam logic [7:0] PEND_BASE     = 8'h0B;
  localparam logic [7:0] MASK_ACT_BASE = 8'h19;
  localparam logic [7:0] OCTL_BASE     = 8'h2B;
  localparam int         ICTL_OFS      = 8;
  localparam int         BANK_STRIDE   = 16;
  localparam logic [5:0] OCTL_RST      = 6'h0A;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic       dir;
    logic       od;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       val;
  } octl_t;

  function automatic logic [7:0] octl_addr(input int pin, input int bank_pins);
    return 8'(int'(OCTL_BASE) + (pin / bank_pins) * BANK_STRIDE + (pin % bank_pins));
  endfunction

  function automatic logic [7:0] ictl_addr(input int pin, input int bank_pins);
    return 8'(int'(octl_addr(pin, bank_pins)) + ICTL_OFS);
  endfunction

  function automatic logic [7:0] pend_addr(input int bank);
    return 8'(int'(PEND_BASE) + bank);
  endfunction

  function automatic logic [7:0] mask_addr(input int bank, input int num_banks, input bit sleep);
    return 8'(int'(MASK_ACT_BASE) + bank + (sleep ? num_banks : 0));
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pin_cell.sv
module pin_cell
  import pin_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       octl_we_i,
  input  logic [5:0] octl_wdata_i,
  input  logic       ictl_we_i,
  input  logic [1:0] esel_wdata_i,
  input  logic       lvl_i,
  input  logic       pend_clr_i,
  output octl_t      octl_o,
  output edge_sel_e  esel_o,
  output logic       prev_o,
  output logic       hit_o,
  output logic       pend_o,
  output logic       pad_oe_o,
  output logic       pad_out_o
);
  octl_t     octl_q;
  edge_sel_e esel_q;
  logic      prev_q, pend_q;
  logic      rise, fall;
  logic [1:0] esel_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      octl_q <= octl_t'(OCTL_RST);
      esel_q <= EDGE_NONE;
    end else begin
      if (octl_we_i) octl_q <= octl_t'(octl_wdata_i);
      if (ictl_we_i) esel_q <= edge_sel_e'(esel_wdata_i);
    end
  end

  assign esel_bits = esel_q;
  assign rise      = lvl_i & ~prev_q;
  assign fall      = ~lvl_i & prev_q;
  assign hit_o     = (esel_bits[1] & rise) | (esel_bits[0] & fall);

  // new edge takes precedence over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= hit_o | (pend_q & ~pend_clr_i);
    end
  end

  // open-drain drives only the low level
  assign pad_oe_o  = octl_q.dir & (~octl_q.od | ~octl_q.val);
  assign pad_out_o = octl_q.val;
  assign octl_o    = octl_q;
  assign esel_o    = esel_q;
  assign prev_o    = prev_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/pin_irq_gate.sv
module pin_irq_gate
  import pin_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 8,
  localparam int NP = NUM_BANKS * BANK_PINS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           addr_i,
  input  logic [BANK_PINS-1:0] wdata_i,
  input  logic                 sleep_i,
  input  logic [NP-1:0]        pend_i,
  output logic [NP-1:0]        mask_act_o,
  output logic [NP-1:0]        mask_slp_o,
  output logic                 irq_o
);
  logic [NP-1:0] act_q, slp_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [7:0] AA = mask_addr(b, NUM_BANKS, 1'b0);
    localparam logic [7:0] SA = mask_addr(b, NUM_BANKS, 1'b1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[b*BANK_PINS +: BANK_PINS] <= '1;
        slp_q[b*BANK_PINS +: BANK_PINS] <= '1;
      end else if (wr_en_i) begin
        if (addr_i == AA) act_q[b*BANK_PINS +: BANK_PINS] <= wdata_i;
        if (addr_i == SA) slp_q[b*BANK_PINS +: BANK_PINS] <= wdata_i;
      end
    end
  end

  assign irq_o      = |(pend_i & ~(sleep_i ? slp_q : act_q));
  assign mask_act_o = act_q;
  assign mask_slp_o = slp_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 8,
  localparam int NP = NUM_BANKS * BANK_PINS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_i,
  input  logic            wr_en_i,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic [NP-1:0]   pad_in_i,
  output logic [NP-1:0]   pad_oe_o,
  output logic [NP-1:0]   pad_out_o,
  output logic [NP-1:0]   pull_en_o,
  output logic [2*NP-1:0] pull_sel_o,
  output logic [NP-1:0]   open_drain_o,
  output logic            irq_o
);
  logic [NP-1:0] lvl_w, prev_w, hit_w, pend_w, dir_w, clr_w;
  logic [NP-1:0] mask_act_w, mask_slp_w;
  octl_t         octl_w [NP];
  edge_sel_e     esel_w [NP];

  pin_sync #(.W(NP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (lvl_w)
  );

  for (genvar n = 0; n < NP; n++) begin : g_pin
    localparam int         B  = n / BANK_PINS;
    localparam int         O  = n % BANK_PINS;
    localparam logic [7:0] OA = octl_addr(n, BANK_PINS);
    localparam logic [7:0] IA = ictl_addr(n, BANK_PINS);
    localparam logic [7:0] PA = pend_addr(B);

    assign clr_w[n] = wr_en_i && (addr_i == PA) && wdata_i[O];

    pin_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .octl_we_i   (wr_en_i && (addr_i == OA)),
      .octl_wdata_i(wdata_i[5:0]),
      .ictl_we_i   (wr_en_i && (addr_i == IA)),
      .esel_wdata_i(wdata_i[2:1]),
      .lvl_i       (lvl_w[n]),
      .pend_clr_i  (clr_w[n]),
      .octl_o      (octl_w[n]),
      .esel_o      (esel_w[n]),
      .prev_o      (prev_w[n]),
      .hit_o       (hit_w[n]),
      .pend_o      (pend_w[n]),
      .pad_oe_o    (pad_oe_o[n]),
      .pad_out_o   (pad_out_o[n])
    );

    assign dir_w[n]            = octl_w[n].dir;
    assign pull_en_o[n]        = octl_w[n].pull_en;
    assign pull_sel_o[2*n +: 2] = octl_w[n].pull_sel;
    assign open_drain_o[n]     = octl_w[n].od;
  end

  pin_irq_gate #(.NUM_BANKS(NUM_BANKS), .BANK_PINS(BANK_PINS)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i[BANK_PINS-1:0]),
    .sleep_i   (sleep_i),
    .pend_i    (pend_w),
    .mask_act_o(mask_act_w),
    .mask_slp_o(mask_slp_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == pend_addr(b))
        rdata_o = 8'(pend_w[b*BANK_PINS +: BANK_PINS]);
      if (addr_i == mask_addr(b, NUM_BANKS, 1'b0))
        rdata_o = 8'(mask_act_w[b*BANK_PINS +: BANK_PINS]);
      if (addr_i == mask_addr(b, NUM_BANKS, 1'b1))
        rdata_o = 8'(mask_slp_w[b*BANK_PINS +: BANK_PINS]);
    end
    for (int n = 0; n < NP; n++) begin
      if (addr_i == octl_addr(n, BANK_PINS))
        rdata_o = {2'b00, octl_w[n]};
      if (addr_i == ictl_addr(n, BANK_PINS))
        rdata_o = {5'b00000, esel_w[n], lvl_w[n]};
    end
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_PINS = 8,
  localparam int NP = NUM_BANKS * BANK_PINS
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [7:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic [NP-1:0] lvl_i,
  input logic [NP-1:0] prev_i,
  input logic [NP-1:0] hit_i,
  input logic [NP-1:0] pend_i,
  input logic [NP-1:0] dir_i,
  input logic [NP-1:0] od_i,
  input logic [NP-1:0] pad_oe_i,
  input logic [NP-1:0] pad_out_i,
  input logic          irq_i
);
  for (genvar n = 0; n < NP; n++) begin : g_pin
    localparam int         O  = n % BANK_PINS;
    localparam logic [7:0] PA = pend_addr(n / BANK_PINS);

    p_edge_needs_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[n]) |-> $past(lvl_i[n] != prev_i[n]));

    p_w1c_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == PA && wdata_i[O] && !hit_i[n]) |=> !pend_i[n]);

    p_pend_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[n] && !(wr_en_i && addr_i == PA && wdata_i[O])) |=> pend_i[n]);

    p_collision_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[n] |=> pend_i[n]);

    p_od_low_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (od_i[n] && pad_oe_i[n]) |-> !pad_out_i[n]);

    p_input_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_i[n] |-> !pad_oe_i[n]);
  end

  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !irq_i);
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .BANK_PINS(BANK_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .lvl_i    (lvl_w),
  .prev_i   (prev_w),
  .hit_i    (hit_w),
  .pend_i   (pend_w),
  .dir_i    (dir_w),
  .od_i     (open_drain_o),
  .pad_oe_i (pad_oe_o),
  .pad_out_i(pad_out_o),
  .irq_i    (irq_o)
);

// File: tb/sim_pin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pin_irq_ctrl;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] pads = '0;
  logic [NP-1:0] oe, pout, pen, od;
  logic [2*NP-1:0] psel;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pads),
    .pad_oe_o(oe), .pad_out_o(pout), .pull_en_o(pen), .pull_sel_o(psel),
    .open_drain_o(od), .irq_o(irq)
  );

  function automatic logic [7:0] oa(input int n);
    return 8'(8'h2B + 16 * (n / 8) + n % 8);
  endfunction
  function automatic logic [7:0] ia(input int n);
    return 8'(oa(n) + 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; write is taken at the next rising edge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] d1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int n = 0; n < NP; n++) begin
      rd_reg(oa(n), d); check("R1 octl reset", d, 8'h0A);
      rd_reg(ia(n), d); check("R1 ictl reset", d, 8'h00);
    end
    for (int a = 8'h0B; a <= 8'h0C; a++) begin rd_reg(8'(a), d); check("R1 pending reset", d, 8'h00); end
    for (int a = 8'h19; a <= 8'h1C; a++) begin rd_reg(8'(a), d); check("R1 mask reset", d, 8'hFF); end
    check("R1 irq reset", irq, 0);

    // R10 unmapped
    rd_reg(8'h00, d); check("R10 unmapped 00", d, 0);
    rd_reg(8'h20, d); check("R10 unmapped 20", d, 0);
    rd_reg(8'h4B, d); check("R10 unmapped 4B", d, 0);
    rd_reg(8'hFF, d); check("R10 unmapped FF", d, 0);

    // R2 R3 R4 sweep of all output-control encodings on every pin
    for (int n = 0; n < NP; n++) begin
      for (int v = 0; v < 64; v++) begin
        logic e_oe;
        wr_reg(oa(n), 8'(v) | 8'hC0);
        rd_reg(oa(n), d); check("R2 octl readback", d, 8'(v));
        e_oe = v[5] && (!v[4] || !v[0]);
        check("R3 pad_oe", oe[n], e_oe);
        check("R3 pad_out", pout[n], v[0]);
        check("R4 pull_en", pen[n], v[3]);
        check("R4 pull_sel", psel[2*n +: 2], v[2:1]);
        check("R4 open_drain", od[n], v[4]);
      end
      if (n > 0) begin rd_reg(oa(n-1), d); check("R2 neighbour kept", d, 8'h3F); end
      if (n < NP-1) begin rd_reg(oa(n+1), d); check("R2 next untouched", d, 8'h0A); end
    end

    // R5 level timing and read-only bit 0
    wr_reg(ia(5), 8'hFF);
    rd_reg(ia(5), d); check("R5 ictl write bit0 ignored", d, 8'h06);
    wr_reg(ia(5), 8'h00);
    pads[5] = 1'b1;
    @(negedge clk); rd_reg(ia(5), d); check("R5 level after 1 edge", d[0], 0);
    @(negedge clk); rd_reg(ia(5), d); check("R5 level after 2 edges", d[0], 1);
    pads[5] = 1'b0;
    repeat (3) @(negedge clk);

    // unmask all for edge sweep
    for (int a = 8'h19; a <= 8'h1A; a++) wr_reg(8'(a), 8'h00);

    // R6 timing: rising edge on pin 11
    wr_reg(ia(11), 8'h04);
    pads[11] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_reg(8'h0C, d); check("R6 pending not before 3rd edge", d, 8'h00);
    check("R6 irq not before 3rd edge", irq, 0);
    @(negedge clk);
    rd_reg(8'h0C, d); check("R6 pending on 3rd edge", d, 8'h08);
    check("R6 irq on 3rd edge", irq, 1);
    wr_reg(ia(11), 8'h00);
    wr_reg(8'h0C, 8'hFF);
    pads[11] = 1'b0;
    repeat (4) @(negedge clk);

    // R6 sweep over pins, edge selections and directions
    for (int n = 0; n < NP; n++) begin
      for (int s = 0; s < 4; s++) begin
        for (int r = 0; r < 2; r++) begin
          logic m;
          wr_reg(ia(n), 8'h00);
          pads[n] = (r == 0);
          repeat (4) @(negedge clk);
          rd_reg(ia(n), d); check("R5 settled level", d[0], (r == 0));
          wr_reg(8'h0B, 8'hFF);
          wr_reg(8'h0C, 8'hFF);
          wr_reg(ia(n), 8'(s << 1));
          rd_reg(ia(n), d); check("R5 edge field readback", d, 8'(s << 1) | 8'(r == 0));
          pads[n] = (r == 1);
          repeat (3) @(negedge clk);
          m = (s == 3) || (s == 2 && r == 1) || (s == 1 && r == 0);
          rd_reg(8'h0B + 8'(n / 8), d);
          check("R6 pending bit", d, m ? 8'(1 << (n % 8)) : 8'h00);
          rd_reg(8'h0B + 8'(1 - n / 8), d);
          check("R6 other bank clear", d, 8'h00);
          check("R6 irq", irq, m);
        end
      end
      wr_reg(ia(n), 8'h00);
    end

    // R7 constant levels with both edges selected
    wr_reg(8'h0B, 8'hFF); wr_reg(8'h0C, 8'hFF);
    pads = 16'hA5C3;
    repeat (4) @(negedge clk);
    wr_reg(8'h0B, 8'hFF); wr_reg(8'h0C, 8'hFF);
    for (int n = 0; n < NP; n++) wr_reg(ia(n), 8'h06);
    repeat (20) @(negedge clk);
    rd_reg(8'h0B, d); check("R7 bank0 constant", d, 0);
    rd_reg(8'h0C, d); check("R7 bank1 constant", d, 0);
    check("R7 irq constant", irq, 0);

    // R8 write-one-to-clear and collision
    pads = ~pads;
    repeat (3) @(negedge clk);
    rd_reg(8'h0B, d); check("R8 all set b0", d, 8'hFF);
    wr_reg(8'h0B, 8'h00);
    rd_reg(8'h0B, d); check("R8 zero write no effect", d, 8'hFF);
    wr_reg(8'h0B, 8'h81);
    rd_reg(8'h0B, d); check("R8 clear selected bits", d, 8'h7E);
    wr_reg(8'h0C, 8'h10);
    rd_reg(8'h0C, d); check("R8 clear bank1 bit4", d, 8'hEF);
    // edge on pin 2 (already pending) coincides with its clear
    pads[2] = ~pads[2];
    @(negedge clk); @(negedge clk);
    wr_reg(8'h0B, 8'h04);
    rd_reg(8'h0B, d); check("R8 edge wins over clear", d, 8'h7E);
    wr_reg(8'h0B, 8'h04);
    rd_reg(8'h0B, d); check("R8 clear after collision", d, 8'h7A);

    // R9 mask sets: all pending set
    pads = ~pads;
    repeat (3) @(negedge clk);
    rd_reg(8'h0B, d); rd_reg(8'h0C, d1);
    check("R9 setup pending", {d1, d}, 16'hFFFF);
    for (int k = 0; k < NP; k++) begin
      logic [15:0] mk;
      mk = ~(16'h1 << k);
      wr_reg(8'h19, mk[7:0]); wr_reg(8'h1A, mk[15:8]);
      wr_reg(8'h1B, 8'hFF);   wr_reg(8'h1C, 8'hFF);
      sleep = 1'b0; #1 check("R9 active unmasked pin", irq, 1);
      sleep = 1'b1; #1 check("R9 sleep masks all", irq, 0);
      wr_reg(8'h19, 8'hFF);   wr_reg(8'h1A, 8'hFF);
      wr_reg(8'h1B, mk[7:0]); wr_reg(8'h1C, mk[15:8]);
      sleep = 1'b1; #1 check("R9 sleep unmasked pin", irq, 1);
      sleep = 1'b0; #1 check("R9 active masks all", irq, 0);
    end
    for (int a = 8'h19; a <= 8'h1C; a++) wr_reg(8'(a), 8'h00);
    wr_reg(8'h0B, 8'hFF); wr_reg(8'h0C, 8'hFF);
    sleep = 1'b1; #1 check("R9 no pending sleep", irq, 0);
    sleep = 1'b0; #1 check("R9 no pending active", irq, 0);
    rd_reg(8'h1B, d); check("R9 sleep mask readback", d, 8'h00);

    finish_run();
  end
endmodule